// File: doc/BRIEF.md
# Alarm Fill Selector

This block decides, bit by bit, what goes out on the receive and transmit data paths of a line interface: the normal traffic, an all-ones alarm fill, or a test pattern. Each direction has two automatic triggers for the alarm fill, each with its own enable bit. One trigger is loss of signal on the line side. The other is loss of signal on the system side. The transmit direction also has a manual force bit that sends the fill whatever the loss-of-signal inputs say. A test pattern that is switched on for a direction always goes out in place of the fill.

The block runs on the local reference clock. In E1 operation this clock is derived from the master clock at 2.048 MHz. A one-cycle strobe, `bit_tick`, marks each bit boundary, and the choice of source changes only on that strobe, so no partial bit is ever sent. Each loss-of-signal input passes through a two-flop synchronizer before it is used. Each direction is a small state machine with three states. NORMAL passes the traffic through. ALARM_FILL drives all ones. TEST_PAT passes the pattern input through. On each strobe the machine moves to TEST_PAT if the pattern is on. Otherwise it moves to ALARM_FILL if an enabled trigger is active. Otherwise it moves to NORMAL. Any state can reach any other state in one step. While receive fill is active, a registered select output asks for the receive clock to come from the reference clock instead of the recovered clock.

Top module: `alarm_fill_sel`

## Requirements
- R1: During and right after reset, both data outputs are 0, `rx_clk_ref_sel` is 0 and both fill status outputs are 0.
- R2: At a `bit_tick`, receive fill is entered when (synchronized line LOS and `rx_en_line_los`) or (synchronized system LOS and `rx_en_sys_los`) holds. A LOS input whose enable is clear has no effect on the receive path.
- R3: At a `bit_tick`, transmit fill is entered when (synchronized line LOS and `tx_en_line_los`) or (synchronized system LOS and `tx_en_sys_los`) holds. A LOS input whose enable is clear has no effect on the transmit path.
- R4: `tx_force_ais` = 1 at a `bit_tick` puts the transmit path into fill whatever the LOS inputs are. It has no effect on the receive path.
- R5: While a direction is in fill, its data output is all ones and its status output (`rx_ais_on` / `tx_ais_on`) is 1. In NORMAL, the data output equals the data input sampled at the last `bit_tick`.
- R6: `rx_clk_ref_sel` is 1 exactly while the receive path is in fill. Transmit fill does not set it.
- R7: A direction whose pattern enable is 1 at a `bit_tick` outputs its pattern input sampled at that tick, whatever the triggers are, and its status output is 0.
- R8: Outputs change only on a clock edge where `bit_tick` is 1. With `bit_tick` low, changes on the data, pattern, force or enable inputs leave all outputs unchanged.
- R9: A LOS input takes effect only after two clock edges of synchronization. A LOS input raised just before two consecutive `bit_tick` edges does not trigger fill on either edge. It does trigger fill on the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | Bit boundary strobe, one cycle wide |
| los_line_async | input | 1 | Line-side loss of signal, asynchronous |
| los_sys_async | input | 1 | System-side loss of signal, asynchronous |
| rx_en_line_los | input | 1 | Enable receive fill on line LOS |
| rx_en_sys_los | input | 1 | Enable receive fill on system LOS |
| tx_en_line_los | input | 1 | Enable transmit fill on line LOS |
| tx_en_sys_los | input | 1 | Enable transmit fill on system LOS |
| tx_force_ais | input | 1 | Manual transmit fill |
| rx_pat_on | input | 1 | Receive test pattern active |
| tx_pat_on | input | 1 | Transmit test pattern active |
| rx_data_in | input | DW | Receive traffic (dual-rail by default) |
| tx_data_in | input | DW | Transmit traffic |
| rx_pat_in | input | DW | Receive test pattern bits |
| tx_pat_in | input | DW | Transmit test pattern bits |
| rx_data_out | output | DW | Selected receive data |
| tx_data_out | output | DW | Selected transmit data |
| rx_clk_ref_sel | output | 1 | 1 selects the reference clock for the receive clock output |
| rx_ais_on | output | 1 | Receive fill active |
| tx_ais_on | output | 1 | Transmit fill active |

## Verification
The hardest case to reach is a LOS edge that lands inside the synchronizer window while bit strobes are arriving back to back. Random trials let the synchronizer settle before each strobe, so they never probe this window. A directed sequence therefore raises line LOS just before two consecutive strobes and checks that neither strobe starts fill, then checks that the third strobe does. Random trials cover every mix of enables, force and pattern bits. After each trial, the inputs are changed with the strobe held low to show that the outputs hold.

// File: rtl/afs_pkg.sv
package afs_pkg;

    // Source selection state of one data direction
    typedef enum logic [1:0] {
        ST_NORMAL   = 2'd0,
        ST_ALARM    = 2'd1,
        ST_TEST_PAT = 2'd2
    } path_state_e;

endpackage

// File: rtl/afs_sync.sv
module afs_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= '0;
                    else        chain_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/afs_path.sv
module afs_path
    import afs_pkg::*;
#(
    parameter int DW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_tick,
    input  logic          los_line,
    input  logic          los_sys,
    input  logic          en_line,
    input  logic          en_sys,
    input  logic          force_fill,
    input  logic          pat_on,
    input  logic [DW-1:0] data_in,
    input  logic [DW-1:0] pat_in,
    output logic [DW-1:0] data_out,
    output logic          fill_on
);

    path_state_e state_q, state_nxt;
    logic        trigger;
    logic [DW-1:0] data_q;
    logic          fill_q;

    assign trigger = (los_line & en_line) | (los_sys & en_sys) | force_fill;

    // Next-state choice: pattern ranks above fill, fill above traffic
    always_comb begin
        state_nxt = state_q;
        if (bit_tick) begin
            if (pat_on)       state_nxt = ST_TEST_PAT;
            else if (trigger) state_nxt = ST_ALARM;
            else              state_nxt = ST_NORMAL;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_NORMAL;
        else        state_q <= state_nxt;
    end

    // Output register, loaded only at a bit boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            fill_q <= 1'b0;
        end else if (bit_tick) begin
            unique case (state_nxt)
                ST_NORMAL:   begin data_q <= data_in; fill_q <= 1'b0; end
                ST_ALARM:    begin data_q <= '1;      fill_q <= 1'b1; end
                ST_TEST_PAT: begin data_q <= pat_in;  fill_q <= 1'b0; end
                default:     begin data_q <= data_in; fill_q <= 1'b0; end
            endcase
        end
    end

    assign data_out = data_q;
    assign fill_on  = fill_q;

    // R5: in the fill state the data register carries all ones
    a_r5_fill_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ALARM) |-> (data_q == '1));

    // R7: pattern enable at a tick wins over every trigger
    a_r7_pattern_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && pat_on) |=> (state_q == ST_TEST_PAT && !fill_q));

    // R4: an active trigger without pattern lands in fill
    a_r4_trigger_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && force_fill && !pat_on) |=> fill_q);

    // R8: no output change between bit boundaries
    a_r8_hold_off_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> ($stable(data_q) && $stable(fill_q)));

endmodule

// File: rtl/alarm_fill_sel.sv
module alarm_fill_sel
    import afs_pkg::*;
#(
    parameter int DW          = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_tick,
    input  logic          los_line_async,
    input  logic          los_sys_async,
    input  logic          rx_en_line_los,
    input  logic          rx_en_sys_los,
    input  logic          tx_en_line_los,
    input  logic          tx_en_sys_los,
    input  logic          tx_force_ais,
    input  logic          rx_pat_on,
    input  logic          tx_pat_on,
    input  logic [DW-1:0] rx_data_in,
    input  logic [DW-1:0] tx_data_in,
    input  logic [DW-1:0] rx_pat_in,
    input  logic [DW-1:0] tx_pat_in,
    output logic [DW-1:0] rx_data_out,
    output logic [DW-1:0] tx_data_out,
    output logic          rx_clk_ref_sel,
    output logic          rx_ais_on,
    output logic          tx_ais_on
);

    localparam int LOS_W = 2;

    logic [LOS_W-1:0] los_sync;
    logic             rx_fill, tx_fill;

    afs_sync #(.W(LOS_W), .STAGES(SYNC_STAGES)) u_los_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({los_sys_async, los_line_async}),
        .q_sync  (los_sync)
    );

    afs_path #(.DW(DW)) u_rx_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .los_line   (los_sync[0]),
        .los_sys    (los_sync[1]),
        .en_line    (rx_en_line_los),
        .en_sys     (rx_en_sys_los),
        .force_fill (1'b0),
        .pat_on     (rx_pat_on),
        .data_in    (rx_data_in),
        .pat_in     (rx_pat_in),
        .data_out   (rx_data_out),
        .fill_on    (rx_fill)
    );

    afs_path #(.DW(DW)) u_tx_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .los_line   (los_sync[0]),
        .los_sys    (los_sync[1]),
        .en_line    (tx_en_line_los),
        .en_sys     (tx_en_sys_los),
        .force_fill (tx_force_ais),
        .pat_on     (tx_pat_on),
        .data_in    (tx_data_in),
        .pat_in     (tx_pat_in),
        .data_out   (tx_data_out),
        .fill_on    (tx_fill)
    );

    assign rx_ais_on      = rx_fill;
    assign tx_ais_on      = tx_fill;
    assign rx_clk_ref_sel = rx_fill;

    // R6: reference clock requested only while receive data is the fill
    a_r6_clk_sel_with_fill: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clk_ref_sel |-> (rx_data_out == '1));

    // R2: receive path ignores LOS when both receive enables are clear
    a_r2_rx_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !rx_en_line_los && !rx_en_sys_los) |=> !rx_ais_on);

endmodule

// File: tb/alarm_fill_sel_tb.sv
module alarm_fill_sel_tb;

    localparam int DW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_tick = 1'b0;
    logic          los_line_async = 1'b0, los_sys_async = 1'b0;
    logic          rx_en_line_los = 1'b0, rx_en_sys_los = 1'b0;
    logic          tx_en_line_los = 1'b0, tx_en_sys_los = 1'b0;
    logic          tx_force_ais = 1'b0;
    logic          rx_pat_on = 1'b0, tx_pat_on = 1'b0;
    logic [DW-1:0] rx_data_in = '0, tx_data_in = '0, rx_pat_in = '0, tx_pat_in = '0;
    logic [DW-1:0] rx_data_out, tx_data_out;
    logic          rx_clk_ref_sel, rx_ais_on, tx_ais_on;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    alarm_fill_sel #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
        .los_line_async(los_line_async), .los_sys_async(los_sys_async),
        .rx_en_line_los(rx_en_line_los), .rx_en_sys_los(rx_en_sys_los),
        .tx_en_line_los(tx_en_line_los), .tx_en_sys_los(tx_en_sys_los),
        .tx_force_ais(tx_force_ais), .rx_pat_on(rx_pat_on), .tx_pat_on(tx_pat_on),
        .rx_data_in(rx_data_in), .tx_data_in(tx_data_in),
        .rx_pat_in(rx_pat_in), .tx_pat_in(tx_pat_in),
        .rx_data_out(rx_data_out), .tx_data_out(tx_data_out),
        .rx_clk_ref_sel(rx_clk_ref_sel), .rx_ais_on(rx_ais_on), .tx_ais_on(tx_ais_on)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // 0 = traffic, 1 = fill, 2 = pattern
    function automatic int pick(input bit pat, input bit trig);
        if (pat)  return 2;
        if (trig) return 1;
        return 0;
    endfunction

    function automatic logic [DW-1:0] sel_data(input int m, input logic [DW-1:0] d,
                                               input logic [DW-1:0] p);
        if (m == 2) return p;
        if (m == 1) return '1;
        return d;
    endfunction

    task automatic check_all(input string ctx, input logic [DW-1:0] erx,
                             input logic [DW-1:0] etx, input bit erf, input bit etf);
        chk(rx_data_out == erx, {ctx, " R5 rx_data"}, rx_data_out, erx);
        chk(tx_data_out == etx, {ctx, " R5 tx_data"}, tx_data_out, etx);
        chk(rx_ais_on == erf, {ctx, " R2 rx_ais"}, rx_ais_on, erf);
        chk(tx_ais_on == etf, {ctx, " R3 tx_ais"}, tx_ais_on, etf);
        chk(rx_clk_ref_sel == erf, {ctx, " R6 clk_sel"}, rx_clk_ref_sel, erf);
    endtask

    task automatic tick_once();
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
    endtask

    task automatic random_trial();
        int mrx, mtx;
        logic [DW-1:0] erx, etx;
        @(negedge clk);
        los_line_async = 1'($urandom);
        los_sys_async  = 1'($urandom);
        rx_en_line_los = 1'($urandom);
        rx_en_sys_los  = 1'($urandom);
        tx_en_line_los = 1'($urandom);
        tx_en_sys_los  = 1'($urandom);
        tx_force_ais   = ($urandom % 4) == 0;
        rx_pat_on      = ($urandom % 4) == 0;
        tx_pat_on      = ($urandom % 4) == 0;
        rx_data_in = DW'($urandom); tx_data_in = DW'($urandom);
        rx_pat_in  = DW'($urandom); tx_pat_in  = DW'($urandom);
        repeat (3) @(negedge clk);
        mrx = pick(rx_pat_on, (los_line_async & rx_en_line_los) | (los_sys_async & rx_en_sys_los));
        mtx = pick(tx_pat_on, (los_line_async & tx_en_line_los) | (los_sys_async & tx_en_sys_los)
                              | tx_force_ais);
        erx = sel_data(mrx, rx_data_in, rx_pat_in);
        etx = sel_data(mtx, tx_data_in, tx_pat_in);
        bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
        check_all("R7 random", erx, etx, mrx == 1, mtx == 1);
        // R8: scramble non-LOS inputs with no tick, outputs must hold
        rx_data_in = ~rx_data_in; tx_data_in = ~tx_data_in;
        rx_pat_in = ~rx_pat_in; tx_pat_in = ~tx_pat_in;
        rx_pat_on = ~rx_pat_on; tx_pat_on = ~tx_pat_on;
        tx_force_ais = ~tx_force_ais; rx_en_line_los = ~rx_en_line_los;
        repeat (2) @(negedge clk);
        check_all("R8 hold", erx, etx, mrx == 1, mtx == 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        rx_data_in = 2'b10; tx_data_in = 2'b01;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_all("R1 in reset", '0, '0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset", '0, '0, 1'b0, 1'b0);

        // R4: force on transmit only, no LOS
        tx_force_ais = 1'b1;
        tick_once();
        check_all("R4 force", 2'b10, '1, 1'b0, 1'b1);
        tx_force_ais = 1'b0;
        tick_once();
        check_all("R4 release", 2'b10, 2'b01, 1'b0, 1'b0);

        // R2/R3: LOS with enables clear is ignored
        los_line_async = 1'b1; los_sys_async = 1'b1;
        repeat (3) @(negedge clk);
        tick_once();
        check_all("R2 R3 disabled", 2'b10, 2'b01, 1'b0, 1'b0);
        los_line_async = 1'b0; los_sys_async = 1'b0;
        repeat (3) @(negedge clk);

        // R9: LOS raised just before two back-to-back ticks
        rx_en_line_los = 1'b1;
        los_line_async = 1'b1;
        bit_tick = 1'b1;
        @(negedge clk);
        chk(rx_ais_on == 1'b0, "R9 first tick", rx_ais_on, 0);
        @(negedge clk);
        chk(rx_ais_on == 1'b0, "R9 second tick", rx_ais_on, 0);
        @(negedge clk) bit_tick = 1'b0;
        chk(rx_ais_on == 1'b1, "R9 third tick", rx_ais_on, 1);
        chk(rx_clk_ref_sel == 1'b1, "R6 rx fill selects ref", rx_clk_ref_sel, 1);
        chk(tx_ais_on == 1'b0, "R3 tx unaffected", tx_ais_on, 0);

        // R7: pattern over fill on receive
        rx_pat_on = 1'b1; rx_pat_in = 2'b01;
        tick_once();
        check_all("R7 pattern", 2'b01, 2'b01, 1'b0, 1'b0);
        rx_pat_on = 1'b0; los_line_async = 1'b0; rx_en_line_los = 1'b0;
        repeat (3) @(negedge clk);

        for (int i = 0; i < 400; i++) random_trial();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule